// File: doc/BRIEF.md
# Batch-Ranked Multi-Thread Memory Request Scheduler

This block sits in front of a multi-bank DRAM channel. It holds pending requests from several hardware threads and picks one request per cycle to send to a bank that reports itself ready. Each request arrives with a thread number, a bank number, a row address and an age stamp. A lower stamp means an older request. Requests are grouped into batches so that no thread starves. Within a batch, threads are served in a fixed rank order, so that the requests of one thread reach different banks close together in time.

A batch is formed only when no request of the previous batch is still waiting. At that point every pending request is a candidate. For each pairing of thread and bank, the oldest requests are flagged, up to a runtime cap. The scheduler then counts the flagged requests of each thread in each bank. A thread whose busiest bank holds fewer flagged requests gets a better rank. This rank order applies in every bank. Forming the batch and computing the rank take three cycles, and nothing issues during them. Requests that arrive while a batch is running stay unflagged until the next batch.

Top module: `batch_rank_sched`

## Requirements
- R1: After reset the buffer is empty, `req_ready` is 1, `iss_valid` is 0 and no bank has an open row.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 exactly when all DEPTH entries hold a request.
- R3: A batch forms only when no flagged request remains. For each thread and bank, it flags the `mark_cap` oldest pending requests of that pair, or all of them if there are fewer. A `mark_cap` value of 0 acts as 1.
- R4: A request accepted after a batch has been flagged stays unflagged until a later batch forms.
- R5: Each thread gets a rank key made of three parts, compared in this order: the largest count of flagged requests it has in any one bank, then its total count of flagged requests, then its thread number. The thread with the smaller key ranks higher. The rank is computed once per batch and is used in every bank.
- R6: The issued request is chosen among requests whose bank is ready. The order of preference is: flagged before unflagged, then row hit before row miss, then higher-ranked thread, then the lower age stamp.
- R7: An unflagged request may issue while flagged requests remain, provided no flagged request has a ready bank. Nothing issues once no flagged request remains.
- R8: At most one request issues per cycle, and only to a bank whose `bank_ready` bit is 1.
- R9: After the last flagged request of a batch issues, there are four cycles with no issue. If requests are pending, the next batch's first request then issues in the fifth cycle.
- R10: Each bank keeps the row of the last request issued to it as its open row. A request is a row hit when its row equals its bank's open row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mark_cap | input | CAP_W | Maximum number of requests flagged per thread and bank in each batch |
| req_valid | input | 1 | A new request is offered |
| req_thread | input | TID_W | Thread number of the new request |
| req_bank | input | BID_W | Bank number of the new request |
| req_row | input | ROW_W | Row address of the new request |
| req_stamp | input | STAMP_W | Age stamp of the new request; lower means older |
| req_ready | output | 1 | At least one buffer entry is free |
| bank_ready | input | NBANK | Per-bank flag: the bank can take a command this cycle |
| iss_valid | output | 1 | A request issues this cycle |
| iss_thread | output | TID_W | Thread number of the issued request |
| iss_bank | output | BID_W | Bank number of the issued request |
| iss_row | output | ROW_W | Row address of the issued request |
| iss_stamp | output | STAMP_W | Age stamp of the issued request |

## Verification
The bench runs a sweep of generated request mixes. Each mix fills the buffer with a different spread of threads, banks and rows, under marking caps of 0, 1, 2, 3 and 7. Small caps split the load into several batches, which tests flagging and re-forming. Large caps put all requests into one batch, where the rank keys and the row-hit ordering decide the order. The issue order is compared with an arithmetic model of batching, ranking and priority. A directed case withholds one bank from readiness to show that a late unflagged request can issue while the batch is blocked. Every run also checks that the buffer reports full and that the gap between batches has the required length.

// File: rtl/sched_pkg.sv
package sched_pkg;
   typedef enum logic [1:0] {
      ST_FORM  = 2'd0,
      ST_LOAD  = 2'd1,
      ST_RANK  = 2'd2,
      ST_SERVE = 2'd3
   } sched_state_e;
endpackage

// File: rtl/sched_mark.sv
// Decides, for each buffer entry, whether it joins the batch being formed.
module sched_mark #(
   parameter int DEPTH   = 16,
   parameter int TID_W   = 2,
   parameter int BID_W   = 2,
   parameter int STAMP_W = 8,
   parameter int CAP_W   = 3,
   parameter int CNT_W   = 5
) (
   input  logic [DEPTH-1:0]              valid,
   input  logic [DEPTH-1:0][TID_W-1:0]   thr,
   input  logic [DEPTH-1:0][BID_W-1:0]   bank,
   input  logic [DEPTH-1:0][STAMP_W-1:0] stamp,
   input  logic [CAP_W-1:0]              cap,
   output logic [DEPTH-1:0]              take
);
   logic [CAP_W-1:0] cap_eff;
   assign cap_eff = (cap == '0) ? CAP_W'(1) : cap;

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
      logic [CNT_W-1:0] older;
      always_comb begin
         older = '0;
         for (int j = 0; j < DEPTH; j++) begin
            if (valid[j] && thr[j] == thr[gi] && bank[j] == bank[gi] &&
                (stamp[j] < stamp[gi] || (stamp[j] == stamp[gi] && j < gi)))
               older = older + CNT_W'(1);
         end
         take[gi] = valid[gi] && (older < CNT_W'(cap_eff));
      end
   end
endmodule

// File: rtl/sched_rank.sv
// Counts flagged requests per thread and bank, then ranks threads.
module sched_rank #(
   parameter int NTHR  = 4,
   parameter int NBANK = 4,
   parameter int DEPTH = 16,
   parameter int TID_W = 2,
   parameter int BID_W = 2,
   parameter int CNT_W = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          do_load,
   input  logic                          do_rank,
   input  logic [DEPTH-1:0]              mk,
   input  logic [DEPTH-1:0][TID_W-1:0]   thr,
   input  logic [DEPTH-1:0][BID_W-1:0]   bank,
   output logic [NTHR-1:0][TID_W-1:0]    rank_pos
);
   localparam int KEY_W = 2*CNT_W + TID_W;

   logic [NTHR-1:0][NBANK-1:0][CNT_W-1:0] load_d, load_q;
   logic [NTHR-1:0][KEY_W-1:0]            key;
   logic [NTHR-1:0][TID_W-1:0]            pos_d;

   always_comb begin
      for (int t = 0; t < NTHR; t++) begin
         for (int b = 0; b < NBANK; b++) begin
            load_d[t][b] = '0;
            for (int i = 0; i < DEPTH; i++)
               if (mk[i] && thr[i] == TID_W'(t) && bank[i] == BID_W'(b))
                  load_d[t][b] = load_d[t][b] + CNT_W'(1);
         end
      end
   end

   always_comb begin
      for (int t = 0; t < NTHR; t++) begin
         logic [CNT_W-1:0] mx, tot;
         mx  = '0;
         tot = '0;
         for (int b = 0; b < NBANK; b++) begin
            tot = tot + load_q[t][b];
            if (load_q[t][b] > mx) mx = load_q[t][b];
         end
         key[t] = {mx, tot, TID_W'(t)};
      end
      for (int t = 0; t < NTHR; t++) begin
         pos_d[t] = '0;
         for (int u = 0; u < NTHR; u++)
            if (key[u] < key[t]) pos_d[t] = pos_d[t] + TID_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_q <= '0;
         for (int t = 0; t < NTHR; t++) rank_pos[t] <= TID_W'(t);
      end else begin
         if (do_load) load_q <= load_d;
         if (do_rank) rank_pos <= pos_d;
      end
   end
endmodule

// File: rtl/sched_pick.sv
// Picks the eligible entry with the smallest priority key; ties go to the lower slot.
module sched_pick #(
   parameter int DEPTH  = 16,
   parameter int KEY_W  = 12,
   parameter int SLOT_W = 4
) (
   input  logic [DEPTH-1:0]            cand,
   input  logic [DEPTH-1:0][KEY_W-1:0] key,
   output logic                        sel_valid,
   output logic [SLOT_W-1:0]           sel_idx
);
   logic [KEY_W-1:0] best;
   always_comb begin
      sel_valid = 1'b0;
      sel_idx   = '0;
      best      = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (cand[i] && (!sel_valid || key[i] < best)) begin
            sel_valid = 1'b1;
            sel_idx   = SLOT_W'(i);
            best      = key[i];
         end
      end
   end
endmodule

// File: rtl/batch_rank_sched.sv
module batch_rank_sched #(
   parameter int NTHR    = 4,
   parameter int NBANK   = 4,
   parameter int DEPTH   = 16,
   parameter int ROW_W   = 8,
   parameter int STAMP_W = 8,
   parameter int CAP_W   = 3,
   localparam int TID_W  = $clog2(NTHR),
   localparam int BID_W  = $clog2(NBANK)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CAP_W-1:0]   mark_cap,
   input  logic               req_valid,
   input  logic [TID_W-1:0]   req_thread,
   input  logic [BID_W-1:0]   req_bank,
   input  logic [ROW_W-1:0]   req_row,
   input  logic [STAMP_W-1:0] req_stamp,
   output logic               req_ready,
   input  logic [NBANK-1:0]   bank_ready,
   output logic               iss_valid,
   output logic [TID_W-1:0]   iss_thread,
   output logic [BID_W-1:0]   iss_bank,
   output logic [ROW_W-1:0]   iss_row,
   output logic [STAMP_W-1:0] iss_stamp
);
   import sched_pkg::*;

   localparam int SLOT_W = $clog2(DEPTH);
   localparam int CNT_W  = $clog2(DEPTH + 1);
   localparam int KEY_W  = 2 + TID_W + STAMP_W;

   if (NTHR < 2 || NTHR != (1 << TID_W)) begin : g_bad_thr
      $error("NTHR must be a power of two of at least 2");
   end
   if (NBANK < 2 || NBANK != (1 << BID_W)) begin : g_bad_bank
      $error("NBANK must be a power of two of at least 2");
   end
   if (DEPTH < 2 || CNT_W < CAP_W) begin : g_bad_depth
      $error("DEPTH too small for the marking cap width");
   end

   sched_state_e state_q;
   logic [DEPTH-1:0]              valid_q, marked_q, take, hit, cand;
   logic [DEPTH-1:0][TID_W-1:0]   thr_q;
   logic [DEPTH-1:0][BID_W-1:0]   bank_q;
   logic [DEPTH-1:0][ROW_W-1:0]   row_q;
   logic [DEPTH-1:0][STAMP_W-1:0] stamp_q;
   logic [DEPTH-1:0][KEY_W-1:0]   key;
   logic [NBANK-1:0]              open_v_q;
   logic [NBANK-1:0][ROW_W-1:0]   open_r_q;
   logic [NTHR-1:0][TID_W-1:0]    rank_pos;
   logic [SLOT_W-1:0]             free_idx, sel_idx;
   logic                          has_free, any_mk, req_fire;

   always_comb begin
      has_free = 1'b0;
      free_idx = '0;
      for (int i = DEPTH-1; i >= 0; i--)
         if (!valid_q[i]) begin
            has_free = 1'b1;
            free_idx = SLOT_W'(i);
         end
   end

   assign req_ready = has_free;
   assign req_fire  = req_valid && has_free;
   assign any_mk    = |(valid_q & marked_q);

   sched_mark #(.DEPTH(DEPTH), .TID_W(TID_W), .BID_W(BID_W), .STAMP_W(STAMP_W),
                .CAP_W(CAP_W), .CNT_W(CNT_W)) u_mark (
      .valid(valid_q), .thr(thr_q), .bank(bank_q), .stamp(stamp_q),
      .cap(mark_cap), .take(take));

   sched_rank #(.NTHR(NTHR), .NBANK(NBANK), .DEPTH(DEPTH), .TID_W(TID_W),
                .BID_W(BID_W), .CNT_W(CNT_W)) u_rank (
      .clk(clk), .rst_n(rst_n),
      .do_load(state_q == ST_LOAD), .do_rank(state_q == ST_RANK),
      .mk(valid_q & marked_q), .thr(thr_q), .bank(bank_q), .rank_pos(rank_pos));

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_key
      assign hit[gi]  = open_v_q[bank_q[gi]] && (open_r_q[bank_q[gi]] == row_q[gi]);
      assign cand[gi] = valid_q[gi] && bank_ready[bank_q[gi]] &&
                        (state_q == ST_SERVE) && any_mk;
      assign key[gi]  = {~marked_q[gi], ~hit[gi], rank_pos[thr_q[gi]], stamp_q[gi]};
   end

   sched_pick #(.DEPTH(DEPTH), .KEY_W(KEY_W), .SLOT_W(SLOT_W)) u_pick (
      .cand(cand), .key(key), .sel_valid(iss_valid), .sel_idx(sel_idx));

   assign iss_thread = thr_q[sel_idx];
   assign iss_bank   = bank_q[sel_idx];
   assign iss_row    = row_q[sel_idx];
   assign iss_stamp  = stamp_q[sel_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_FORM;
         valid_q  <= '0;
         marked_q <= '0;
         open_v_q <= '0;
      end else begin
         case (state_q)
            ST_FORM:  if (|valid_q) begin
                         marked_q <= take;
                         state_q  <= ST_LOAD;
                      end
            ST_LOAD:  state_q <= ST_RANK;
            ST_RANK:  state_q <= ST_SERVE;
            default:  if (!any_mk) state_q <= ST_FORM;
         endcase
         if (iss_valid) begin
            valid_q[sel_idx]  <= 1'b0;
            marked_q[sel_idx] <= 1'b0;
            open_v_q[iss_bank] <= 1'b1;
         end
         if (req_fire) begin
            valid_q[free_idx]  <= 1'b1;
            marked_q[free_idx] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (iss_valid) open_r_q[iss_bank] <= iss_row;
      if (req_fire) begin
         thr_q[free_idx]   <= req_thread;
         bank_q[free_idx]  <= req_bank;
         row_q[free_idx]   <= req_row;
         stamp_q[free_idx] <= req_stamp;
      end
   end
endmodule

// File: rtl/batch_rank_sched_chk.sv
module batch_rank_sched_chk #(
   parameter int NTHR  = 4,
   parameter int NBANK = 4,
   parameter int DEPTH = 16,
   parameter int TID_W = 2,
   parameter int BID_W = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NBANK-1:0]           bank_ready,
   input logic                       iss_valid,
   input logic [BID_W-1:0]           iss_bank,
   input logic [DEPTH-1:0]           valid_q,
   input logic [DEPTH-1:0]           marked_q,
   input sched_pkg::sched_state_e    state_q,
   input logic [NTHR-1:0][TID_W-1:0] rank_pos
);
   import sched_pkg::*;

   AST_ISSUE_BANK_READY: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> bank_ready[iss_bank]); // R8

   AST_NO_ISSUE_OUT_OF_SERVE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_SERVE) |-> !iss_valid); // R9

   AST_ISSUE_NEEDS_BATCH: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> (|(valid_q & marked_q))); // R7

   AST_MARK_ONLY_ON_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) != ST_FORM) |->
      ($countones(valid_q & marked_q) <= $past($countones(valid_q & marked_q)))); // R4

   for (genvar gp = 0; gp < NTHR; gp++) begin : g_perm
      logic [NTHR-1:0] holds;
      for (genvar gt = 0; gt < NTHR; gt++) begin : g_t
         assign holds[gt] = (rank_pos[gt] == TID_W'(gp));
      end
      AST_RANK_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(holds) == 1); // R5
   end
endmodule

bind batch_rank_sched batch_rank_sched_chk #(
   .NTHR(NTHR), .NBANK(NBANK), .DEPTH(DEPTH), .TID_W(TID_W), .BID_W(BID_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bank_ready(bank_ready), .iss_valid(iss_valid),
   .iss_bank(iss_bank), .valid_q(valid_q), .marked_q(marked_q),
   .state_q(state_q), .rank_pos(rank_pos)
);

// File: tb/batch_rank_sched_test.sv
module batch_rank_sched_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mark_cap = 3'd1;
   logic       req_valid = 1'b0;
   logic [1:0] req_thread = '0;
   logic [1:0] req_bank = '0;
   logic [7:0] req_row = '0;
   logic [7:0] req_stamp = '0;
   logic       req_ready;
   logic [3:0] bank_ready = '0;
   logic       iss_valid;
   logic [1:0] iss_thread;
   logic [1:0] iss_bank;
   logic [7:0] iss_row;
   logic [7:0] iss_stamp;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   int m_t[16], m_b[16], m_r[16], m_s[16];
   bit m_v[16], m_mk[16];
   bit open_v[4];
   int open_r[4];
   int exp_s[16];
   int n_exp;
   int obs_s[16];

   always #10 clk = ~clk;

   batch_rank_sched uut (
      .clk(clk), .rst_n(rst_n), .mark_cap(mark_cap), .req_valid(req_valid),
      .req_thread(req_thread), .req_bank(req_bank), .req_row(req_row),
      .req_stamp(req_stamp), .req_ready(req_ready), .bank_ready(bank_ready),
      .iss_valid(iss_valid), .iss_thread(iss_thread), .iss_bank(iss_bank),
      .iss_row(iss_row), .iss_stamp(iss_stamp));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; req_valid = 1'b0; bank_ready = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic push(input int t, input int b, input int r, input int s);
      @(negedge clk);
      req_valid = 1'b1; req_thread = 2'(t); req_bank = 2'(b);
      req_row = 8'(r); req_stamp = 8'(s);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   function automatic int pick_best(input int rank[4]);
      int best, bk, k;
      best = -1; bk = 0;
      for (int i = 0; i < 16; i++) begin
         if (m_v[i]) begin
            bit h;
            h = open_v[m_b[i]] && open_r[m_b[i]] == m_r[i];
            k = (m_mk[i] ? 0 : 1000000) + (h ? 0 : 100000) + rank[m_t[i]] * 1000 + m_s[i];
            if (best < 0 || k < bk) begin best = i; bk = k; end
         end
      end
      return best;
   endfunction

   // Request-level model of batching (R3), ranking (R5), priority (R6), open rows (R10)
   task automatic model_run(input int cap);
      int cap_e, rank[4], key[4], any_v, any_m, c, mx, tot, sel;
      cap_e = (cap == 0) ? 1 : cap;
      forever begin
         any_v = 0;
         for (int i = 0; i < 16; i++) any_v += m_v[i];
         if (any_v == 0) break;
         for (int i = 0; i < 16; i++) begin
            c = 0;
            for (int j = 0; j < 16; j++)
               if (m_v[j] && m_t[j] == m_t[i] && m_b[j] == m_b[i] && m_s[j] < m_s[i]) c++;
            m_mk[i] = m_v[i] && (c < cap_e);
         end
         for (int t = 0; t < 4; t++) begin
            mx = 0; tot = 0;
            for (int b = 0; b < 4; b++) begin
               c = 0;
               for (int i = 0; i < 16; i++) if (m_mk[i] && m_t[i] == t && m_b[i] == b) c++;
               tot += c;
               if (c > mx) mx = c;
            end
            key[t] = mx * 4096 + tot * 16 + t;
         end
         for (int t = 0; t < 4; t++) begin
            rank[t] = 0;
            for (int u = 0; u < 4; u++) if (key[u] < key[t]) rank[t]++;
         end
         forever begin
            any_m = 0;
            for (int i = 0; i < 16; i++) any_m += m_mk[i];
            if (any_m == 0) break;
            sel = pick_best(rank);
            exp_s[n_exp++] = m_s[sel];
            open_v[m_b[sel]] = 1'b1; open_r[m_b[sel]] = m_r[sel];
            m_v[sel] = 1'b0; m_mk[sel] = 1'b0;
         end
      end
   endtask

   task automatic scenario(input int sid, input int cap);
      int n_obs, gap, first_bad, mt, mb, mr, pr;
      do_reset();
      mark_cap = 3'(cap);
      mt = 1 + sid % 3; mb = sid % 4 + 1; mr = sid % 2 + 1; pr = sid % 3;
      for (int i = 0; i < 16; i++) begin
         m_v[i] = 1'b0; m_mk[i] = 1'b0;
      end
      for (int b = 0; b < 4; b++) begin open_v[b] = 1'b0; open_r[b] = 0; end
      n_exp = 0;
      exp_s[n_exp++] = 0;
      open_v[0] = 1'b1; open_r[0] = pr;
      push(0, 0, pr, 0);
      repeat (6) @(negedge clk);
      for (int i = 1; i < 16; i++) begin
         m_v[i] = 1'b1; m_mk[i] = 1'b0;
         m_t[i] = (i * mt + sid) % 4;
         m_b[i] = (i * mb + i / 3) % 4;
         m_r[i] = (i * mr) % 3;
         m_s[i] = i;
         push(m_t[i], m_b[i], m_r[i], m_s[i]);
      end
      #1 check(req_ready == 1'b0, "R2 buffer full after 16 accepts", req_ready, 0);
      model_run(cap);
      n_obs = 0; gap = 0;
      @(negedge clk);
      bank_ready = 4'hF;
      for (int cyc = 0; cyc < 300 && n_obs < 16; cyc++) begin
         #1;
         if (iss_valid) obs_s[n_obs++] = int'(iss_stamp);
         else if (n_obs == 1) gap++;
         @(negedge clk);
      end
      check(gap == 4, "R9 idle cycles before next batch", gap, 4);
      first_bad = -1;
      for (int i = 0; i < 16; i++)
         if (first_bad < 0 && (i >= n_obs || obs_s[i] != exp_s[i])) first_bad = i;
      if (first_bad < 0)
         check(1'b1, "R3 R5 R6 R10 issue order", 0, 0);
      else
         check(1'b0, "R3 R5 R6 R10 issue order (stamp at first mismatch)",
               first_bad < n_obs ? obs_s[first_bad] : -1, exp_s[first_bad]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      do_reset();
      #1;
      check(iss_valid == 1'b0, "R1 no issue after reset", iss_valid, 0);
      check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

      // R4 R7 R8: late unflagged request issues while the batch's bank is blocked
      do_reset();
      mark_cap = 3'd2;
      push(0, 0, 5, 0);
      repeat (6) @(negedge clk);
      push(1, 2, 7, 1);
      @(negedge clk);
      bank_ready = 4'b0100;
      #1 check(iss_valid && iss_stamp == 8'd1, "R7 R4 unflagged issues to free bank",
               iss_valid ? int'(iss_stamp) : -1, 1);
      @(negedge clk);
      #1 check(iss_valid == 1'b0, "R8 no issue to a bank that is not ready", iss_valid, 0);
      @(negedge clk);
      bank_ready = 4'hF;
      #1 check(iss_valid && iss_stamp == 8'd0, "R8 flagged issues once bank ready",
               iss_valid ? int'(iss_stamp) : -1, 0);

      for (int sid = 0; sid < 8; sid++) begin
         int cap;
         case (sid)
            0: cap = 0; 1: cap = 1; 2: cap = 2; 3: cap = 3;
            4: cap = 7; 5: cap = 1; 6: cap = 2; default: cap = 7;
         endcase
         scenario(sid, cap);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule